// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block guards a protected storage array with two 64-bit secrets: one that opens reads and one that opens writes. A host streams an 8-byte candidate into the block over a valid/ready byte interface, most-significant byte first, then pulses a check strobe with a select naming which secret to test. Every check, right or wrong, is followed by a fixed busy period that stands in for a self-timed nonvolatile cycle, and the outcome becomes visible only when that period ends.

Wrong attempts from either select feed one shared miss counter. A correct attempt clears it. A miss arriving when the counter is already at its limit wipes both secrets to zero and raises a one-cycle erase request toward the array. After a successful write-secret check, the host may replace either secret by streaming exactly eight new bytes and pulsing the change strobe. The new value takes effect when the busy period of that change ends. No output ever carries a secret.

Stream rules: a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole busy period. The host must hold `in_valid` and `in_data` until that period is over. The candidate buffer empties at the end of every busy period.

Top module: `pw_verifier`

## Requirements
- R1: After reset, `busy`, `pass`, `fail` and `erase_req` are 0 and `in_ready` is 1. Both secrets are all zeros, so a check of eight 0x00 bytes passes for either select.
- R2: A candidate byte is accepted only when `in_valid` and `in_ready` are both high, and `in_ready` is 0 throughout the busy period. The first accepted byte becomes bits 63:56 of the candidate.
- R3: A check passes only if exactly eight bytes were accepted since the last busy period ended and they equal the selected secret. Seven bytes or nine bytes fail.
- R4: Every accepted check or change holds `busy` high for exactly BUSY_CYCLES clock cycles. `pass` and `fail` are both 0 while `busy` is high.
- R5: When busy falls, exactly one of `pass` and `fail` is set. It stays set, and the other stays clear, until the next accepted command.
- R6: The two secrets are independent. `chk_sel` = 0 tests the read secret and `chk_sel` = 1 tests the write secret, and a value that matches one does not pass against the other.
- R7: Misses with either select count on one shared counter, and a passing check clears it. MAX_MISSES misses in a row cause no erase.
- R8: A miss that arrives with MAX_MISSES misses already counted raises `erase_req` for exactly one cycle, in the cycle where `busy` falls. It also clears both secrets and the counter to zero.
- R9: `chg_go` is ignored, so `busy` does not rise and the secrets are unchanged, unless all of these hold: the most recent command was a passing write-secret check, and exactly eight bytes have been loaded since it ended.
- R10: An accepted change writes the loaded value into the secret chosen by `chg_sel` (0 read, 1 write) when busy ends, and reports `pass`.
- R11: `check_go` and `chg_go` pulses while `busy` is high are ignored. They neither lengthen nor restart the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Candidate byte present |
| in_ready | output | 1 | Block can take a byte (low while busy) |
| in_data | input | BYTE_W | Candidate byte, MSB first |
| chk_sel | input | 1 | Secret to check: 0 read, 1 write |
| check_go | input | 1 | Start a check of the loaded candidate |
| chg_sel | input | 1 | Secret to replace: 0 read, 1 write |
| chg_go | input | 1 | Replace the chosen secret with the loaded bytes |
| busy | output | 1 | Self-timed cycle in progress |
| pass | output | 1 | Last command succeeded |
| fail | output | 1 | Last check was wrong |
| erase_req | output | 1 | One-cycle request to clear the protected array |

## Verification
The hardest state to reach is the wipe. The counter has to sit exactly at its limit before one more miss arrives, and a single correct check anywhere in the run resets it. The stimulus first brings both secrets to distinct non-zero values through the guarded change path. It then interleaves wrong read and wrong write checks up to the limit and confirms that no erase occurs. A correct write check clears the count, and the same run of misses is repeated, followed by one further miss that must raise the erase pulse and return both secrets to zero.

// File: rtl/pwv_pkg.sv
package pwv_pkg;
  typedef enum logic {SEL_RD = 1'b0, SEL_WR = 1'b1} pw_sel_e;
  typedef struct packed {
    logic    is_change;
    pw_sel_e sel;
  } pend_op_t;
endpackage

// File: rtl/pwv_cand_shift.sv
module pwv_cand_shift #(
  parameter int BYTES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTES*BYTE_W-1:0] value,
  output logic                    exact
);
  localparam int VW = BYTES * BYTE_W;
  localparam int CW = $clog2(BYTES + 2);
  localparam logic [CW-1:0] FULL = CW'(BYTES);
  localparam logic [CW-1:0] OVER = CW'(BYTES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      cnt   <= '0;
    end else if (clr) begin
      value <= '0;
      cnt   <= '0;
    end else if (push) begin
      value <= {value[VW-BYTE_W-1:0], din};
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end
  end

  assign exact = (cnt == FULL);
endmodule

// File: rtl/pwv_retry_ctr.sv
module pwv_retry_ctr #(
  parameter int MAX_MISSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miss,
  input  logic hit,
  output logic wipe
);
  localparam int MW = $clog2(MAX_MISSES + 1);
  localparam logic [MW-1:0] LIMIT = MW'(MAX_MISSES);

  logic [MW-1:0] cnt;

  assign wipe = miss && (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (hit || wipe) cnt <= '0;
    else if (miss)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwv_busy_timer.sv
module pwv_busy_timer #(
  parameter int BUSY_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(BUSY_CYCLES);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (cnt != '0)          cnt <= cnt - 1'b1;
    else if (start)              cnt <= LOAD;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == TW'(1));
endmodule

// File: rtl/pw_verifier.sv
module pw_verifier
  import pwv_pkg::*;
#(
  parameter int BYTES       = 8,
  parameter int BYTE_W      = 8,
  parameter int BUSY_CYCLES = 20,
  parameter int MAX_MISSES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              chk_sel,
  input  logic              check_go,
  input  logic              chg_sel,
  input  logic              chg_go,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic              erase_req
);
  localparam int PW_W   = BYTES * BYTE_W;
  localparam int NUM_PW = 2;

  logic [PW_W-1:0] cand;
  logic            cand_exact;
  logic            done;
  logic            wipe;
  logic            wr_ok;
  pend_op_t        pend;
  logic [NUM_PW-1:0][PW_W-1:0] pw_all;

  assign in_ready = !busy;

  logic chk_fire, chg_fire, start, match, hit, miss;
  assign chk_fire = check_go && !busy;
  assign chg_fire = chg_go && !busy && !check_go && wr_ok && cand_exact;
  assign start    = chk_fire || chg_fire;
  assign match    = cand_exact && (cand == pw_all[pend.sel]);
  assign hit      = done && !pend.is_change && match;
  assign miss     = done && !pend.is_change && !match;

  pwv_cand_shift #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_cand (
    .clk(clk), .rst_n(rst_n), .clr(done), .push(in_valid && in_ready),
    .din(in_data), .value(cand), .exact(cand_exact)
  );

  pwv_retry_ctr #(.MAX_MISSES(MAX_MISSES)) u_retry (
    .clk(clk), .rst_n(rst_n), .miss(miss), .hit(hit), .wipe(wipe)
  );

  pwv_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  // One register per secret slot; each loads on a committed change to it.
  for (genvar g = 0; g < NUM_PW; g++) begin : gen_slot
    logic [PW_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wipe)
        q <= '0;
      else if (done && pend.is_change && (int'(pend.sel) == g))
        q <= cand;
    end
    assign pw_all[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ok     <= 1'b0;
      pend      <= '{is_change: 1'b0, sel: SEL_RD};
      pass      <= 1'b0;
      fail      <= 1'b0;
      erase_req <= 1'b0;
    end else begin
      erase_req <= 1'b0;
      if (chk_fire) begin
        pend  <= '{is_change: 1'b0, sel: pw_sel_e'(chk_sel)};
        pass  <= 1'b0;
        fail  <= 1'b0;
        wr_ok <= 1'b0;
      end else if (chg_fire) begin
        pend  <= '{is_change: 1'b1, sel: pw_sel_e'(chg_sel)};
        pass  <= 1'b0;
        fail  <= 1'b0;
        wr_ok <= 1'b0;
      end
      if (done) begin
        if (pend.is_change) begin
          pass <= 1'b1;
        end else if (match) begin
          pass  <= 1'b1;
          wr_ok <= (pend.sel == SEL_WR);
        end else begin
          fail      <= 1'b1;
          erase_req <= wipe;
        end
      end
    end
  end
endmodule

// File: rtl/pw_verifier_chk.sv
module pw_verifier_chk #(
  parameter int BUSY_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic check_go,
  input logic chg_go,
  input logic busy,
  input logic pass,
  input logic fail,
  input logic erase_req
);
  localparam int RW = $clog2(BUSY_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == RW'(BUSY_CYCLES)));

  assert_hidden_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pass && !fail));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_outcome_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !check_go && !chg_go) |=> ($stable(pass) && $stable(fail)));

  assert_erase_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  assert_erase_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ($fell(busy) && fail));

  assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind pw_verifier pw_verifier_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .check_go(check_go),
  .chg_go(chg_go), .busy(busy), .pass(pass), .fail(fail), .erase_req(erase_req)
);

// File: tb/tb_pw_verifier.sv
module tb_pw_verifier;
  localparam int BUSY = 20;
  localparam int MAXM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic chk_sel = 1'b0, check_go = 1'b0, chg_sel = 1'b0, chg_go = 1'b0;
  logic busy, pass, fail, erase_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pw_verifier #(.BUSY_CYCLES(BUSY), .MAX_MISSES(MAXM)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .chk_sel(chk_sel), .check_go(check_go),
    .chg_sel(chg_sel), .chg_go(chg_go), .busy(busy), .pass(pass),
    .fail(fail), .erase_req(erase_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Load n bytes MSB first; bytes beyond eight are 0x00.
  task automatic load(input logic [63:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = (i < 8) ? val[63-8*i -: 8] : 8'h00;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Pulse a strobe, then sample busy length and the result after it.
  task automatic run_cmd(input bit is_chg, input logic sel, output int blen,
                         output logic er, input int mid_pulse);
    if (is_chg) begin chg_sel = sel; chg_go = 1'b1; end
    else        begin chk_sel = sel; check_go = 1'b1; end
    @(negedge clk);
    chg_go = 1'b0; check_go = 1'b0;
    blen = 0;
    while (busy && blen < 1000) begin
      if (blen == 0) chk(!in_ready, "R2 ready low while busy", in_ready, 0);
      if (blen == mid_pulse) begin check_go = 1'b1; chg_go = 1'b1; end
      else begin check_go = 1'b0; chg_go = 1'b0; end
      blen++;
      @(negedge clk);
    end
    check_go = 1'b0; chg_go = 1'b0;
    er = erase_req;
  endtask

  task automatic attempt(input logic sel, input logic [63:0] val, input int n,
                         input bit exp_pass, input string tag, output logic er);
    int blen;
    load(val, n);
    run_cmd(1'b0, sel, blen, er, -1);
    chk(blen == BUSY, {tag, " R4 busy length"}, blen, BUSY);
    chk(pass == exp_pass && fail == !exp_pass, tag, {pass, fail}, {exp_pass, !exp_pass});
  endtask

  task automatic change(input logic sel, input logic [63:0] val, input string tag);
    int blen;
    logic er;
    load(val, 8);
    run_cmd(1'b1, sel, blen, er, -1);
    chk(blen == BUSY, {tag, " R10 change busy length"}, blen, BUSY);
    chk(pass && !fail, {tag, " R10 change pass"}, {pass, fail}, 2'b10);
  endtask

  typedef struct packed {
    logic        sel;
    logic [3:0]  n;
    logic [63:0] val;
    logic        exp_pass;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{sel: 1'b0, n: 4'd8, val: 64'h0, exp_pass: 1'b1},
    '{sel: 1'b1, n: 4'd8, val: 64'h0, exp_pass: 1'b1},
    '{sel: 1'b0, n: 4'd7, val: 64'h0, exp_pass: 1'b0},
    '{sel: 1'b0, n: 4'd9, val: 64'h0, exp_pass: 1'b0},
    '{sel: 1'b1, n: 4'd8, val: 64'h0000_0000_0000_0001, exp_pass: 1'b0},
    '{sel: 1'b0, n: 4'd8, val: 64'h0, exp_pass: 1'b1}
  };

  localparam logic [63:0] PW_A = 64'hA5C3_1F00_7E42_9BD6;
  localparam logic [63:0] PW_B = 64'h1234_5678_9ABC_DEF0;

  initial begin
    logic er;
    int blen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !pass && !fail && !erase_req && in_ready, "R1 reset outputs",
        {busy, pass, fail, erase_req, in_ready}, 5'b00001);

    // Table: zero secrets, byte-count edges, shared counter cleared by the final pass
    foreach (VECS[i]) begin
      attempt(VECS[i].sel, VECS[i].val, int'(VECS[i].n), VECS[i].exp_pass,
              $sformatf("R3 vector %0d", i), er);
      chk(!er, "R7 no erase on table", er, 0);
    end

    // R5 fail persists
    attempt(1'b0, 64'h1, 8, 1'b0, "R3 wrong read", er);
    repeat (5) @(negedge clk);
    chk(fail && !pass, "R5 fail held", {pass, fail}, 2'b01);

    // Set write secret to A (R10), then check independence (R6)
    attempt(1'b1, 64'h0, 8, 1'b1, "R1 zero write secret", er);
    change(1'b1, PW_A, "R10 write to A");
    repeat (4) @(negedge clk);
    chk(pass && !fail, "R5 pass held", {pass, fail}, 2'b10);
    attempt(1'b1, 64'h0, 8, 1'b0, "R10 old write value rejected", er);
    attempt(1'b1, PW_A, 8, 1'b1, "R10 new write value", er);
    attempt(1'b0, PW_A, 8, 1'b0, "R6 write value on read select", er);

    // R9: wr_ok cleared by an intervening read check
    attempt(1'b1, PW_A, 8, 1'b1, "R9 write grant", er);
    attempt(1'b0, 64'h0, 8, 1'b1, "R9 read zero", er);
    load(PW_B, 8);
    chg_sel = 1'b0; chg_go = 1'b1; @(negedge clk); chg_go = 1'b0;
    chk(!busy, "R9 change without grant ignored", busy, 0);
    @(negedge clk);
    chk(!busy && pass, "R9 outputs untouched", {busy, pass}, 2'b01);
    // pending 8 bytes of B are checked against read secret (still zero)
    run_cmd(1'b0, 1'b0, blen, er, -1);
    chk(fail, "R9 read secret unchanged", fail, 1);
    attempt(1'b0, 64'h0, 8, 1'b1, "R9 read still zero", er);

    // R9: change with seven bytes ignored
    attempt(1'b1, PW_A, 8, 1'b1, "R9 write grant 2", er);
    load(PW_B, 7);
    chg_sel = 1'b0; chg_go = 1'b1; @(negedge clk); chg_go = 1'b0;
    chk(!busy, "R9 seven-byte change ignored", busy, 0);
    run_cmd(1'b0, 1'b0, blen, er, -1);
    chk(fail, "R3 seven bytes fail", fail, 1);

    // Set read secret to B
    attempt(1'b1, PW_A, 8, 1'b1, "R9 write grant 3", er);
    change(1'b0, PW_B, "R10 read to B");
    attempt(1'b0, PW_B, 8, 1'b1, "R10 read B", er);
    attempt(1'b1, PW_B, 8, 1'b0, "R6 read value on write select", er);
    attempt(1'b1, PW_A, 8, 1'b1, "R7 clear count", er);

    // R11 strobes during busy ignored
    load(PW_B, 8);
    run_cmd(1'b0, 1'b0, blen, er, 5);
    chk(blen == BUSY, "R11 busy not extended", blen, BUSY);
    chk(pass, "R11 result intact", pass, 1);
    @(negedge clk);
    chk(!busy, "R11 no restart", busy, 0);

    // R7: MAXM mixed misses, no erase; pass clears; repeat then wipe (R8)
    for (int k = 0; k < MAXM; k++) begin
      attempt(k[0], 64'hDEAD, 8, 1'b0, "R7 mixed miss", er);
      chk(!er, "R7 no erase within limit", er, 0);
    end
    attempt(1'b1, PW_A, 8, 1'b1, "R7 pass clears counter", er);
    for (int k = 0; k < MAXM; k++) begin
      attempt(!k[0], 64'hBEEF, 8, 1'b0, "R7 second miss run", er);
      chk(!er, "R7 counter was cleared", er, 0);
    end
    attempt(1'b0, 64'hBEEF, 8, 1'b0, "R8 overflow miss", er);
    chk(er == 1'b1, "R8 erase pulse at busy end", er, 1);
    @(negedge clk);
    chk(!erase_req, "R8 erase one cycle", erase_req, 0);
    attempt(1'b0, 64'h0, 8, 1'b1, "R8 read secret zero", er);
    attempt(1'b1, 64'h0, 8, 1'b1, "R8 write secret zero", er);
    attempt(1'b1, PW_A, 8, 1'b0, "R8 old write value gone", er);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule